// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block sorts a bank of interrupt request lines by programmable urgency and offers a single winner to a processor core. Each line holds a four-bit priority that occupies the upper nibble of an 8-bit value, so the value is a multiple of 0x10. A numerically smaller value is more urgent, and zero is the most urgent. A 3-bit grouping setting splits every priority into two parts. The upper part, the group, decides whether a request may interrupt a running handler. The lower part, the sub-priority, only orders requests that are waiting.

The block keeps a pending bit and an active bit for every line. The current execution level is the most urgent group among the active lines. The block presents the best pending request only when its group is strictly more urgent than that level. It reports the request as an exception number, which is the line index plus 16. The core takes the request, receives an acknowledge one cycle later, and returns the exception number when the handler finishes. Handlers nest as deep as the group levels allow.

Top module: `irq_nest_arbiter`

## Requirements
- R1: A priority write stores only data bits [7:4]. A read of the same line returns those bits with bits [3:0] as zero, so 0xA7 reads back as 0xA0. Lines reset to 0x00 and the grouping setting resets to 0.
- R2: A rising edge on `irq_in[i]` sets the pending bit of line i at that clock edge. With no handler active, `req_valid` is then 1 and `req_excnum` equals i+16. After reset `req_valid` is 0.
- R3: Among pending lines whose groups differ, the line with the numerically lowest group is presented.
- R4: Among pending lines with the same group, the line with the lowest sub-priority is presented. With grouping 4, the values 0x80 and 0x90 share group 0x80, and 0x80 wins.
- R5: When priority values are equal, the lowest line index is presented.
- R6: A request is presented only if its group is strictly lower than `exec_level`. A pending line in the same group as the running handler stays waiting, even if its sub-priority is more urgent.
- R7: A cycle with `take` high while `req_valid` is high clears that line's pending bit and sets its active bit. One cycle later `ack` is 1 and `ack_excnum` equals the taken number. `exec_level` then reports the taken line's group. A `take` with `req_valid` low does nothing.
- R8: `ret` with `ret_excnum` = i+16 clears the active bit of line i. From the next cycle, `exec_level` is recomputed and any held request is presented. `exec_level` is 256 when no line is active.
- R9: An edge on a line that is already active sets its pending bit again. That line is not presented again before its handler returns.
- R10: A grouping setting n makes value bits [7:n+1] the group. When n is 3 or less, all four stored bits are group bits. With n = 7 every line has group 0, so no request nests over a running handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_LINES | Request lines; a rising edge sets the line's pending bit |
| prio_we | input | 1 | Priority write strobe |
| prio_waddr | input | LINE_W | Line index to write |
| prio_wdata | input | 8 | Priority value; bits [7:4] are kept |
| prio_raddr | input | LINE_W | Line index to read |
| prio_rdata | output | 8 | Stored priority of the read line, low nibble zero |
| grp_we | input | 1 | Grouping setting write strobe |
| grp_wdata | input | 3 | Grouping split point n |
| req_valid | output | 1 | A request may be taken |
| req_excnum | output | 8 | Exception number of the presented request (line + 16) |
| take | input | 1 | Core takes the presented request |
| ack | output | 1 | Pulses one cycle after an accepted take |
| ack_excnum | output | 8 | Exception number that was taken |
| ret | input | 1 | Handler return strobe |
| ret_excnum | input | 8 | Exception number being returned |
| exec_level | output | 9 | Current group level; 256 when no line is active |

## Verification
Pending, active and acknowledge state are registered, so every result is due one clock edge after its stimulus.

| Stimulus | Result due one edge later |
|---|---|
| Request edge | `req_valid` and `req_excnum` |
| Take | `ack`, `ack_excnum`, the new `exec_level` and the next presented request |
| Return | The recomputed level and any held request |
| Priority or grouping write | The value on `prio_rdata` and its effect on arbitration |

The bench changes inputs only on falling clock edges and samples one falling edge later. That is exactly one rising edge after the stimulus, which is where each result must appear. Each scenario drains every handler it opens, so the next scenario starts from an idle level.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants and the group-extraction function for the
// nested interrupt priority arbiter.
package irq_arb_pkg;
    localparam int          PRIO_IMPL  = 4;       // stored priority bits
    localparam int          EXC_OFFSET = 16;      // line index to exception number
    localparam logic [8:0]  IDLE_LEVEL = 9'h100;  // level with no active handler

    // Returns the group part of a stored nibble under grouping setting n.
    // Bits [7:n+1] are the group, with the value kept at its 8-bit weight.
    function automatic logic [7:0] grp_of(input logic [PRIO_IMPL-1:0] p,
                                          input logic [2:0] n);
        logic [8:0] mask;
        mask = 9'h1FF << ({1'b0, n} + 4'd1);
        return {p, 4'b0000} & mask[7:0];
    endfunction
endpackage

// File: rtl/irq_prio_store.sv
// Module: irq_prio_store
// Holds one priority nibble per line and the grouping setting. It has one
// write port and one combinational read port. Assumes the write address is
// a valid line index; an out-of-range index writes nothing.
module irq_prio_store #(
    parameter int N_LINES = 32,
    parameter int LINE_W  = $clog2(N_LINES)
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       we,
    input  logic [LINE_W-1:0]                          waddr,
    input  logic [7:0]                                 wdata,
    input  logic [LINE_W-1:0]                          raddr,
    input  logic                                       grp_we,
    input  logic [2:0]                                 grp_wdata,
    output logic [N_LINES-1:0][irq_arb_pkg::PRIO_IMPL-1:0] prio_q,
    output logic [2:0]                                 grp_q,
    output logic [7:0]                                 rdata
);
    import irq_arb_pkg::*;

    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_line
            // Per-line priority register: keeps the upper nibble only.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio_q[gi] <= '0;
                else if (we && (int'(waddr) == gi))
                    prio_q[gi] <= wdata[7:8-PRIO_IMPL];
            end
        end
    endgenerate

    // Grouping setting register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp_q <= 3'd0;
        else if (grp_we)
            grp_q <= grp_wdata;
    end

    // Read path: stored nibble with the low bits forced to zero.
    always_comb rdata = {prio_q[raddr], {(8-PRIO_IMPL){1'b0}}};
endmodule

// File: rtl/irq_line_state.sv
// Module: irq_line_state
// Keeps the pending and active bits of every line. A rising request edge
// sets pending. A take moves one line from pending to active. A return
// clears one active bit. Assumes the caller only issues a take for a line
// that is actually presented.
module irq_line_state #(
    parameter int N_LINES = 32,
    parameter int LINE_W  = $clog2(N_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LINES-1:0]  irq_in,
    input  logic                take_fire,
    input  logic [LINE_W-1:0]   take_line,
    input  logic                ret_fire,
    input  logic [LINE_W-1:0]   ret_line,
    output logic [N_LINES-1:0]  pending_q,
    output logic [N_LINES-1:0]  active_q
);
    logic [N_LINES-1:0] irq_prev_q;
    logic [N_LINES-1:0] edge_set;
    logic [N_LINES-1:0] take_mask;
    logic [N_LINES-1:0] ret_mask;

    // Decode request edges and the one-hot take and return masks.
    always_comb begin
        edge_set  = irq_in & ~irq_prev_q;
        take_mask = take_fire ? (N_LINES'(1) << take_line) : '0;
        ret_mask  = ret_fire  ? (N_LINES'(1) << ret_line)  : '0;
    end

    // Sample the request lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_prev_q <= '0;
        else        irq_prev_q <= irq_in;
    end

    // Pending: a new edge sets the bit; a take clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~take_mask) | edge_set;
    end

    // Active: a take sets the bit; a return clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= '0;
        else        active_q <= (active_q & ~ret_mask) | take_mask;
    end
endmodule

// File: rtl/irq_pick.sv
// Module: irq_pick
// Combinational arbitration. It finds the most urgent pending line, using
// full priority first and the lowest index on ties. It also finds the
// current execution level, the most urgent group among active lines.
// The full 4-bit value orders group before sub-priority, because the group
// bits are always the upper bits.
module irq_pick #(
    parameter int N_LINES = 32,
    parameter int LINE_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0][irq_arb_pkg::PRIO_IMPL-1:0] prio_q,
    input  logic [2:0]                                     grp_q,
    input  logic [N_LINES-1:0]                             pending_q,
    input  logic [N_LINES-1:0]                             active_q,
    output logic                                           win_valid,
    output logic [LINE_W-1:0]                              win_line,
    output logic [7:0]                                     win_grp,
    output logic [8:0]                                     level
);
    import irq_arb_pkg::*;

    logic [PRIO_IMPL-1:0] best_p;

    // Linear scan for the winner; a strict compare keeps the lowest index.
    always_comb begin
        win_valid = 1'b0;
        best_p    = '1;
        win_line  = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (pending_q[i] && (!win_valid || prio_q[i] < best_p)) begin
                win_valid = 1'b1;
                best_p    = prio_q[i];
                win_line  = LINE_W'(i);
            end
        end
        win_grp = grp_of(best_p, grp_q);
    end

    // Execution level: minimum group over active lines, idle otherwise.
    always_comb begin
        level = IDLE_LEVEL;
        for (int i = 0; i < N_LINES; i++) begin
            if (active_q[i] && ({1'b0, grp_of(prio_q[i], grp_q)} < level))
                level = {1'b0, grp_of(prio_q[i], grp_q)};
        end
    end
endmodule

// File: rtl/irq_nest_arbiter.sv
// Module: irq_nest_arbiter (top)
// Nested interrupt priority arbiter. It presents the best pending request
// only when its group is strictly more urgent than the current execution
// level. It accepts take, return and acknowledge handshakes with the core.
// Assumes N_LINES <= 240, so that exception numbers fit in 8 bits.
module irq_nest_arbiter #(
    parameter int N_LINES = 32,
    parameter int LINE_W  = $clog2(N_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LINES-1:0]  irq_in,
    input  logic                prio_we,
    input  logic [LINE_W-1:0]   prio_waddr,
    input  logic [7:0]          prio_wdata,
    input  logic [LINE_W-1:0]   prio_raddr,
    output logic [7:0]          prio_rdata,
    input  logic                grp_we,
    input  logic [2:0]          grp_wdata,
    output logic                req_valid,
    output logic [7:0]          req_excnum,
    input  logic                take,
    output logic                ack,
    output logic [7:0]          ack_excnum,
    input  logic                ret,
    input  logic [7:0]          ret_excnum,
    output logic [8:0]          exec_level
);
    import irq_arb_pkg::*;

    logic [N_LINES-1:0][PRIO_IMPL-1:0] prio_q;
    logic [2:0]                        grp_q;
    logic [N_LINES-1:0]                pending_q;
    logic [N_LINES-1:0]                active_q;
    logic                              win_valid;
    logic [LINE_W-1:0]                 win_line;
    logic [7:0]                        win_grp;
    logic                              take_fire;
    logic                              ret_fire;
    logic [7:0]                        ret_off;

    irq_prio_store #(.N_LINES(N_LINES), .LINE_W(LINE_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (prio_we),
        .waddr     (prio_waddr),
        .wdata     (prio_wdata),
        .raddr     (prio_raddr),
        .grp_we    (grp_we),
        .grp_wdata (grp_wdata),
        .prio_q    (prio_q),
        .grp_q     (grp_q),
        .rdata     (prio_rdata)
    );

    irq_line_state #(.N_LINES(N_LINES), .LINE_W(LINE_W)) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .take_fire (take_fire),
        .take_line (win_line),
        .ret_fire  (ret_fire),
        .ret_line  (ret_off[LINE_W-1:0]),
        .pending_q (pending_q),
        .active_q  (active_q)
    );

    irq_pick #(.N_LINES(N_LINES), .LINE_W(LINE_W)) i_pick (
        .prio_q    (prio_q),
        .grp_q     (grp_q),
        .pending_q (pending_q),
        .active_q  (active_q),
        .win_valid (win_valid),
        .win_line  (win_line),
        .win_grp   (win_grp),
        .level     (exec_level)
    );

    // Preemption gate and the handshake decode.
    always_comb begin
        req_valid  = win_valid && ({1'b0, win_grp} < exec_level);
        req_excnum = 8'(win_line) + 8'(EXC_OFFSET);
        take_fire  = take && req_valid;
        ret_off    = ret_excnum - 8'(EXC_OFFSET);
        ret_fire   = ret && (ret_excnum >= 8'(EXC_OFFSET)) && (int'(ret_off) < N_LINES);
    end

    // Acknowledge register: one-cycle pulse carrying the taken number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack        <= 1'b0;
            ack_excnum <= '0;
        end else begin
            ack        <= take_fire;
            ack_excnum <= take_fire ? req_excnum : ack_excnum;
        end
    end
endmodule

// File: rtl/irq_arb_chk.sv
// Module: irq_arb_chk
// Property checker for irq_nest_arbiter, attached to it by bind. It observes
// the ports together with the stored priorities and the line state.
module irq_arb_chk #(
    parameter int N_LINES = 32,
    parameter int LINE_W  = $clog2(N_LINES)
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic                                         req_valid,
    input logic [7:0]                                   req_excnum,
    input logic                                         take,
    input logic                                         ack,
    input logic [7:0]                                   ack_excnum,
    input logic [8:0]                                   exec_level,
    input logic [N_LINES-1:0][irq_arb_pkg::PRIO_IMPL-1:0] prio_q,
    input logic [2:0]                                   grp_q,
    input logic [N_LINES-1:0]                           active_q
);
    import irq_arb_pkg::*;

    logic [7:0]        req_off;
    logic [LINE_W-1:0] req_line;
    logic [8:0]        req_grp;

    // Group of the presented line, taken from the stored priorities.
    always_comb begin
        req_off  = req_excnum - 8'(EXC_OFFSET);
        req_line = req_off[LINE_W-1:0];
        req_grp  = {1'b0, grp_of(prio_q[req_line], grp_q)};
    end

    // R7
    ack_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_valid) |=> (ack && ack_excnum == $past(req_excnum)));

    // R7
    no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && req_valid) |=> !ack);

    // R2
    excnum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_excnum >= 8'(EXC_OFFSET) && int'(req_off) < N_LINES));

    // R6
    strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_grp < exec_level));

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q == '0) |-> (exec_level == IDLE_LEVEL));

    // R9
    no_reenter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !active_q[req_line]);
endmodule

bind irq_nest_arbiter irq_arb_chk #(.N_LINES(N_LINES), .LINE_W(LINE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_excnum (req_excnum),
    .take       (take),
    .ack        (ack),
    .ack_excnum (ack_excnum),
    .exec_level (exec_level),
    .prio_q     (prio_q),
    .grp_q      (grp_q),
    .active_q   (active_q)
);

// File: tb/test_irq_nest_arbiter.sv
// Directed bench for irq_nest_arbiter: one task per scenario.
module test_irq_nest_arbiter;
    localparam int N  = 32;
    localparam int LW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          prio_we = 1'b0;
    logic [LW-1:0] prio_waddr = '0;
    logic [7:0]    prio_wdata = '0;
    logic [LW-1:0] prio_raddr = '0;
    logic [7:0]    prio_rdata;
    logic          grp_we = 1'b0;
    logic [2:0]    grp_wdata = '0;
    logic          req_valid;
    logic [7:0]    req_excnum;
    logic          take = 1'b0;
    logic          ack;
    logic [7:0]    ack_excnum;
    logic          ret = 1'b0;
    logic [7:0]    ret_excnum = '0;
    logic [8:0]    exec_level;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    irq_nest_arbiter #(.N_LINES(N)) i_irq_nest_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .prio_we(prio_we), .prio_waddr(prio_waddr), .prio_wdata(prio_wdata),
        .prio_raddr(prio_raddr), .prio_rdata(prio_rdata),
        .grp_we(grp_we), .grp_wdata(grp_wdata),
        .req_valid(req_valid), .req_excnum(req_excnum),
        .take(take), .ack(ack), .ack_excnum(ack_excnum),
        .ret(ret), .ret_excnum(ret_excnum), .exec_level(exec_level)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_prio(input int line, input logic [7:0] v);
        prio_we = 1'b1; prio_waddr = LW'(line); prio_wdata = v;
        tick();
        prio_we = 1'b0;
    endtask

    task automatic set_grp(input logic [2:0] n);
        grp_we = 1'b1; grp_wdata = n;
        tick();
        grp_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] lines);
        irq_in = lines;
        tick();
        irq_in = '0;
    endtask

    task automatic do_take();
        take = 1'b1;
        tick();
        take = 1'b0;
    endtask

    task automatic do_ret(input int exc);
        ret = 1'b1; ret_excnum = 8'(exc);
        tick();
        ret = 1'b0;
    endtask

    // Reset state check.
    task automatic t_reset();
        chk(int'(req_valid), 0, "R2 reset req_valid");
        chk(int'(ack), 0, "R7 reset ack");
        chk(int'(exec_level), 256, "R8 reset idle level");
        prio_raddr = 5'd9;
        #0 chk(int'(prio_rdata), 0, "R1 reset priority");
    endtask

    // Priority storage keeps the upper nibble only.
    task automatic t_prio_rw();
        set_prio(5, 8'hA7);
        set_prio(31, 8'hFF);
        prio_raddr = 5'd5;
        #1 chk(int'(prio_rdata), 'hA0, "R1 readback 0xA7");
        prio_raddr = 5'd31;
        #1 chk(int'(prio_rdata), 'hF0, "R1 readback 0xFF");
        set_prio(5, 8'h00);
        set_prio(31, 8'h00);
    endtask

    // Single request, take, acknowledge and return.
    task automatic t_basic();
        set_grp(3'd0);
        set_prio(3, 8'h70);
        pulse(N'(1) << 3);
        chk(int'(req_valid), 1, "R2 request presented");
        chk(int'(req_excnum), 19, "R2 excnum line3");
        do_take();
        chk(int'(ack), 1, "R7 ack pulse");
        chk(int'(ack_excnum), 19, "R7 ack excnum");
        chk(int'(exec_level), 'h70, "R7 level after take");
        chk(int'(req_valid), 0, "R7 request cleared");
        tick();
        chk(int'(ack), 0, "R7 ack one cycle");
        do_ret(19);
        chk(int'(exec_level), 256, "R8 idle after return");
    endtask

    // Group ordering, blocked lower group, release on return.
    task automatic t_order();
        set_prio(10, 8'hA0);
        set_prio(11, 8'h70);
        pulse((N'(1) << 10) | (N'(1) << 11));
        chk(int'(req_excnum), 27, "R3 lower group first");
        do_take();
        chk(int'(req_valid), 0, "R6 less urgent held");
        do_ret(27);
        chk(int'(req_valid), 1, "R8 held request released");
        chk(int'(req_excnum), 26, "R8 released line10");
        do_take();
        do_ret(26);
    endtask

    // Sub-priority order, same-group blocking, strict nesting.
    task automatic t_sub();
        set_grp(3'd4);
        set_prio(20, 8'h90);
        set_prio(21, 8'h80);
        set_prio(22, 8'h60);
        pulse((N'(1) << 20) | (N'(1) << 21));
        chk(int'(req_excnum), 37, "R4 lower sub first");
        do_take();
        chk(int'(exec_level), 'h80, "R10 group of 0x80 at n=4");
        chk(int'(req_valid), 0, "R6 same group no nest");
        pulse(N'(1) << 22);
        chk(int'(req_valid), 1, "R6 lower group nests");
        chk(int'(req_excnum), 38, "R6 nest excnum");
        do_take();
        do_ret(38);
        chk(int'(req_valid), 0, "R6 still blocked after inner return");
        do_ret(37);
        chk(int'(req_excnum), 36, "R8 line20 after return");
        do_take();
        do_ret(36);
        set_grp(3'd0);
    endtask

    // Equal priority goes to the lowest index.
    task automatic t_tie();
        set_prio(7, 8'h50);
        set_prio(4, 8'h50);
        pulse((N'(1) << 7) | (N'(1) << 4));
        chk(int'(req_excnum), 20, "R5 lowest index");
        do_take();
        do_ret(20);
        chk(int'(req_excnum), 23, "R5 next line7");
        do_take();
        do_ret(23);
    endtask

    // Re-edge on an active line stays pending until the return.
    task automatic t_reenter();
        set_prio(2, 8'h30);
        pulse(N'(1) << 2);
        do_take();
        pulse(N'(1) << 2);
        chk(int'(req_valid), 0, "R9 no self re-entry");
        do_ret(18);
        chk(int'(req_valid), 1, "R9 serviced after return");
        chk(int'(req_excnum), 18, "R9 excnum");
        do_take();
        do_ret(18);
        chk(int'(exec_level), 256, "R9 drained");
    endtask

    // Grouping 7: no group bits, so nothing nests.
    task automatic t_group7();
        set_grp(3'd7);
        set_prio(1, 8'hF0);
        set_prio(0, 8'h00);
        pulse(N'(1) << 1);
        do_take();
        chk(int'(exec_level), 0, "R10 n=7 group zero");
        pulse(N'(1) << 0);
        chk(int'(req_valid), 0, "R10 n=7 no nesting");
        do_take();
        chk(int'(ack), 0, "R7 take ignored when no request");
        do_ret(17);
        chk(int'(req_excnum), 16, "R10 line0 after return");
        do_take();
        do_ret(16);
        set_grp(3'd0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_prio_rw();
        t_basic();
        t_order();
        t_sub();
        t_tie();
        t_reenter();
        t_group7();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule